// File: doc/BRIEF.md
# Two-Axis Angular-Rate Output Conditioner

This block sits between the filtered angular-rate datapath of a two-axis gyroscope and its output register bank. Each time a pair of raw signed 16-bit rate samples arrives with a valid strobe, it corrects each axis by a user calibration offset, optionally negates each axis, optionally exchanges the two channels, and clamps the result to the 16-bit signed range. The conditioned pair appears on the outputs one clock later, with its own valid strobe, and is held there until the next valid pair.

The calibration offsets are 7-bit two's-complement counts. One count equals roughly one degree per second of rate, so its weight in output LSBs depends on the full-scale range in use: 257 LSB per count in the narrow range, 128 LSB per count in the wide range. The offset on the first axis is subtracted and the offset on the second axis is added, so the two counts have opposite polarity. The offset is applied first, then the sign inversion, then the channel exchange.

Top module: `rate_cond_top`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` is 0 and both outputs are 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: The X channel value before sign and swap is `raw_x - off_x * K`, where `off_x` is signed 7-bit and K is the per-count weight.
- R4: The Y channel value before sign and swap is `raw_y + off_y * K`, where `off_y` is signed 7-bit.
- R5: K is 257 when `cfg_wide_fs` is 0 and 128 when `cfg_wide_fs` is 1.
- R6: When `cfg_neg_x` (or `cfg_neg_y`) is 1, the offset-corrected X (or Y) value is negated before clamping.
- R7: When `cfg_swap` is 0, `out_a` carries the X channel and `out_b` the Y channel; when 1, `out_a` carries Y and `out_b` carries X.
- R8: Each output is clamped to the range -32768 to 32767 instead of wrapping, including the negation of -32768, which yields 32767.
- R9: In a cycle after `in_valid` was 0, `out_a` and `out_b` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw sample pair valid |
| raw_x | input | 16 | Raw X rate sample, two's complement |
| raw_y | input | 16 | Raw Y rate sample, two's complement |
| cfg_swap | input | 1 | Exchange the two output channels |
| cfg_neg_x | input | 1 | Negate the X channel |
| cfg_neg_y | input | 1 | Negate the Y channel |
| cfg_wide_fs | input | 1 | Full-scale select: 0 narrow (257 LSB/count), 1 wide (128 LSB/count) |
| cfg_off_x | input | 7 | X calibration offset, two's complement counts |
| cfg_off_y | input | 7 | Y calibration offset, two's complement counts |
| out_valid | output | 1 | Conditioned pair valid |
| out_a | output | 16 | First output channel |
| out_b | output | 16 | Second output channel |

## Verification
The bench drives the extreme offsets (-64 and +63) on samples near both rails, so a design that wrapped instead of clamping would show a sign flip at full scale, and it negates -32768 to catch an output of -32768 where 32767 belongs. It applies the same nonzero offset to both axes to expose a design that gave both the same polarity, switches the full-scale select to catch a wrong or unswitched weight, and pairs negation with swap to catch an exchange applied before the negation, which would invert the wrong output. Idle gaps between samples show whether the outputs are held or overwritten.

// File: rtl/rc_pkg.sv
package rc_pkg;

    // Identifies which physical axis a conditioning lane serves; the
    // offset polarity is selected from it.
    typedef enum logic {
        AXIS_X = 1'b0,
        AXIS_Y = 1'b1
    } axis_e;

endpackage

// File: rtl/rc_offset_scale.sv
module rc_offset_scale #(
    parameter int OFFS_W  = 7,
    parameter int WIDE_W  = 19,
    parameter int STEP_LO = 257,
    parameter int STEP_HI = 128
) (
    input  logic [OFFS_W-1:0]        off_cnt,
    input  logic                     wide_fs,
    output logic signed [WIDE_W-1:0] off_lsb
);

    logic signed [WIDE_W-1:0] cnt_ext;
    logic signed [WIDE_W-1:0] weight;

    always_comb begin
        cnt_ext = WIDE_W'($signed(off_cnt));
        weight  = wide_fs ? WIDE_W'(STEP_HI) : WIDE_W'(STEP_LO);
        off_lsb = cnt_ext * weight;
    end

endmodule

// File: rtl/rc_axis_path.sv
module rc_axis_path
    import rc_pkg::*;
#(
    parameter int    SAMPLE_W = 16,
    parameter int    WIDE_W   = 19,
    parameter axis_e AXIS     = AXIS_X
) (
    input  logic [SAMPLE_W-1:0]        raw,
    input  logic signed [WIDE_W-1:0]   off_lsb,
    input  logic                       negate,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam logic signed [WIDE_W-1:0] MAX_W = WIDE_W'((1 << (SAMPLE_W-1)) - 1);
    localparam logic signed [WIDE_W-1:0] MIN_W = -WIDE_W'(1 << (SAMPLE_W-1));

    logic signed [WIDE_W-1:0] raw_w;
    logic signed [WIDE_W-1:0] corr_w;
    logic signed [WIDE_W-1:0] signed_w;

    assign raw_w = WIDE_W'($signed(raw));

    generate
        if (AXIS == AXIS_X) begin : g_neg_pol
            assign corr_w = raw_w - off_lsb;
        end else begin : g_pos_pol
            assign corr_w = raw_w + off_lsb;
        end
    endgenerate

    always_comb begin
        signed_w = negate ? -corr_w : corr_w;
        if (signed_w > MAX_W) begin
            result = MAX_W[SAMPLE_W-1:0];
        end else if (signed_w < MIN_W) begin
            result = MIN_W[SAMPLE_W-1:0];
        end else begin
            result = signed_w[SAMPLE_W-1:0];
        end
    end

    // R8
    always_comb begin
        clamp_range_chk: assert (!(negate && corr_w == MIN_W) || result == MAX_W[SAMPLE_W-1:0])
            else $error("clamp of negated minimum failed");
    end

endmodule

// File: rtl/rate_cond_top.sv
module rate_cond_top
    import rc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int OFFS_W   = 7,
    parameter int STEP_LO  = 257,
    parameter int STEP_HI  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] raw_x,
    input  logic [SAMPLE_W-1:0] raw_y,
    input  logic                cfg_swap,
    input  logic                cfg_neg_x,
    input  logic                cfg_neg_y,
    input  logic                cfg_wide_fs,
    input  logic [OFFS_W-1:0]   cfg_off_x,
    input  logic [OFFS_W-1:0]   cfg_off_y,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_a,
    output logic [SAMPLE_W-1:0] out_b
);

    localparam int WIDE_W = SAMPLE_W + 3;
    localparam int N_AX   = 2;

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] a;
        logic [SAMPLE_W-1:0] b;
    } state_t;

    state_t st_d, st_q;

    logic [SAMPLE_W-1:0]        raw_v [N_AX];
    logic [OFFS_W-1:0]          off_v [N_AX];
    logic                       neg_v [N_AX];
    logic signed [WIDE_W-1:0]   lsb_v [N_AX];
    logic signed [SAMPLE_W-1:0] res_v [N_AX];

    assign raw_v[0] = raw_x;
    assign raw_v[1] = raw_y;
    assign off_v[0] = cfg_off_x;
    assign off_v[1] = cfg_off_y;
    assign neg_v[0] = cfg_neg_x;
    assign neg_v[1] = cfg_neg_y;

    generate
        for (genvar i = 0; i < N_AX; i++) begin : g_lane
            localparam axis_e LANE_AXIS = (i == 0) ? AXIS_X : AXIS_Y;

            rc_offset_scale #(
                .OFFS_W (OFFS_W),
                .WIDE_W (WIDE_W),
                .STEP_LO(STEP_LO),
                .STEP_HI(STEP_HI)
            ) u_scale (
                .off_cnt(off_v[i]),
                .wide_fs(cfg_wide_fs),
                .off_lsb(lsb_v[i])
            );

            rc_axis_path #(
                .SAMPLE_W(SAMPLE_W),
                .WIDE_W  (WIDE_W),
                .AXIS    (LANE_AXIS)
            ) u_path (
                .raw    (raw_v[i]),
                .off_lsb(lsb_v[i]),
                .negate (neg_v[i]),
                .result (res_v[i])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.a = cfg_swap ? res_v[1] : res_v[0];
            st_d.b = cfg_swap ? res_v[0] : res_v[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_a     = st_q.a;
    assign out_b     = st_q.b;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_a) && $stable(out_b)));

    // R7
    straight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_swap && !cfg_neg_x && cfg_off_x == '0)
        |=> out_a == $past(raw_x));

    // R7
    crossed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_swap && !cfg_neg_y && cfg_off_y == '0)
        |=> out_a == $past(raw_y));

endmodule

// File: tb/rate_cond_top_test.sv
module rate_cond_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] raw_x = '0;
    logic [15:0] raw_y = '0;
    logic        cfg_swap = 1'b0;
    logic        cfg_neg_x = 1'b0;
    logic        cfg_neg_y = 1'b0;
    logic        cfg_wide_fs = 1'b0;
    logic [6:0]  cfg_off_x = '0;
    logic [6:0]  cfg_off_y = '0;
    logic        out_valid;
    logic [15:0] out_a;
    logic [15:0] out_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // pending expectation for the next sample point
    int    exp_a = 0;
    int    exp_b = 0;
    bit    exp_v = 1'b0;
    string exp_tag = "R1";

    always #2 clk = ~clk;

    rate_cond_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .raw_x(raw_x), .raw_y(raw_y),
        .cfg_swap(cfg_swap), .cfg_neg_x(cfg_neg_x), .cfg_neg_y(cfg_neg_y),
        .cfg_wide_fs(cfg_wide_fs), .cfg_off_x(cfg_off_x), .cfg_off_y(cfg_off_y),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    function automatic int clamp16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int s7(logic [6:0] v);
        return v[6] ? int'(v) - 128 : int'(v);
    endfunction

    function automatic int s16(logic [15:0] v);
        return v[15] ? int'(v) - 65536 : int'(v);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        check(exp_tag, int'(out_valid), int'(exp_v), "out_valid");
        check(exp_tag, s16(out_a), exp_a, "out_a");
        check(exp_tag, s16(out_b), exp_b, "out_b");
    endtask

    // Advance one cycle: check the outputs produced by the previous
    // stimulus, then apply a new one and predict its effect.
    task automatic step(bit v, int rx, int ry, bit sw, bit nx, bit ny,
                        bit fs, int ox, int oy, string tag);
        int k, cx, cy;
        @(negedge clk);
        compare_now();
        in_valid    = v;
        raw_x       = 16'(rx);
        raw_y       = 16'(ry);
        cfg_swap    = sw;
        cfg_neg_x   = nx;
        cfg_neg_y   = ny;
        cfg_wide_fs = fs;
        cfg_off_x   = 7'(ox);
        cfg_off_y   = 7'(oy);
        exp_v   = v;
        exp_tag = tag;
        if (v) begin
            k  = fs ? 128 : 257;
            cx = s16(raw_x) - s7(cfg_off_x) * k;
            cy = s16(raw_y) + s7(cfg_off_y) * k;
            if (nx) cx = -cx;
            if (ny) cy = -cy;
            cx = clamp16(cx);
            cy = clamp16(cy);
            exp_a = sw ? cy : cx;
            exp_b = sw ? cx : cy;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        compare_now();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after release with no input
        compare_now();

        step(1, 1234, -4321, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 1000, 1000, 0, 0, 0, 0, 5, 0, "R3");
        step(1, 1000, 1000, 0, 0, 0, 0, 0, 5, "R4");
        step(1, 1000, 1000, 0, 0, 0, 0, -3, -3, "R4");
        step(1, 0, 0, 0, 0, 0, 1, 10, -10, "R5");
        step(1, 0, 0, 0, 0, 0, 0, 10, -10, "R5");
        step(1, 500, -700, 0, 1, 0, 0, 1, 0, "R6");
        step(1, 500, -700, 0, 0, 1, 0, 0, 1, "R6");
        step(1, 111, 222, 1, 0, 0, 0, 0, 0, "R7");
        step(1, 111, 222, 1, 1, 0, 0, 2, 0, "R7");
        step(1, 32000, -32000, 0, 0, 0, 0, -64, -64, "R8");
        step(1, -32000, 32000, 0, 0, 0, 0, 63, 63, "R8");
        step(1, -32768, -32768, 0, 1, 1, 0, 0, 0, "R8");
        step(1, 32767, 32767, 1, 1, 0, 1, -64, 63, "R8");
        step(0, 9, 9, 1, 1, 1, 1, 7, 7, "R9");
        step(0, -5, 5, 0, 0, 0, 0, 1, 1, "R9");
        step(1, 42, 43, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 300; i++) begin
            step(bit'($urandom_range(0, 3) != 0),
                 int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 65535)) - 32768,
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 127)) - 64,
                 int'($urandom_range(0, 127)) - 64, "R3");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        compare_now();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule